// File: doc/BRIEF.md
# In-System Configuration Mode Tracker

This block follows the in-system-configuration mode of a programmable device. A TAP controller and an instruction decoder elsewhere in the chip supply single-cycle strobes: power-up reset, TAP reset (the controller has reached Test-Logic-Reset), instruction loaded and instruction executed. Each instruction strobe comes with a decoded instruction class. The block keeps a four-state mode register and a done flag that it takes from the configuration logic. It reports the mode along with two status bits, enabled and done, which the I/O control logic uses to decide how the pins behave.

The mode moves from Unprogrammed to Accessed when the enable instruction executes. It leaves Accessed when the disable instruction is loaded or executed, and the captured done flag chooses where it goes. From the Complete state, a TAP reset with done set makes the device Operational. All updates happen on one system clock edge and are qualified by the strobes. When several strobes arrive in the same cycle, a fixed priority decides which one acts.

Top module: `isc_mode_tracker`

## Requirements
- R1: After `rst_n` is asserted, or after a cycle with `porEvt` high, `mode` reads 2'b00 (Unprogrammed) and both `iscEnabled` and `iscDone` read 0. The mode codes are 2'b00 Unprogrammed, 2'b01 Accessed, 2'b10 Complete and 2'b11 Operational.
- R2: An instruction execute (`execEvt`) with `insnKind` 2'b01 (enable) moves the block to Accessed on the next clock edge from Unprogrammed, Complete or Operational, and sets `iscEnabled` to 1. The instruction class codes are 2'b00 test, 2'b01 enable, 2'b10 disable and 2'b11 other.
- R3: While the block is in Accessed and stays there, `doneIn` is captured on each clock edge, and `iscDone` shows the captured value one cycle later.
- R4: In Accessed, either loading or executing a disable instruction (2'b10) makes the block leave Accessed on the next edge with `iscEnabled` 0. If the captured done is 1 it goes to Complete and keeps done at 1; if the captured done is 0 it goes to Unprogrammed. The decision uses the done value captured before that cycle.
- R5: A `tlrEvt` in Complete with done set moves the block to Operational, where `iscEnabled` is 0 and `iscDone` is 1.
- R6: Loading or executing a test-class or other-class instruction leaves the mode and done unchanged.
- R7: `tlrEvt` has no effect in Unprogrammed, Accessed or Operational.
- R8: When strobes coincide, power-up reset wins over TAP reset, and TAP reset wins over instruction strobes.
- R9: Entering Unprogrammed clears done. Outside Accessed, changes on `doneIn` have no effect on `iscDone`.
- R10: Loading the enable instruction without executing it does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porEvt | input | 1 | Power-up reset strobe |
| tlrEvt | input | 1 | TAP reached Test-Logic-Reset |
| loadEvt | input | 1 | Instruction loaded strobe |
| execEvt | input | 1 | Instruction executed strobe |
| insnKind | input | 2 | Decoded class of the current instruction |
| doneIn | input | 1 | Done flag from configuration logic |
| mode | output | 2 | Current mode code |
| iscEnabled | output | 1 | Accessed-mode status bit |
| iscDone | output | 1 | Captured done status bit |

## Verification
Two things can happen in the same cycle: a reset event and an instruction event, and a done capture and a disable decision. The bench raises power-up reset together with an enable execute, a TAP reset together with an enable execute while in Complete, and both reset strobes together. It then checks that the mode matches the higher-priority event only. It also changes `doneIn` in the same cycle as a disable load and checks that the exit follows the done value captured earlier, not the new one.

// File: rtl/isc_mode_pkg.sv
package isc_mode_pkg;
  localparam int ModeW = 2;
  localparam int KindW = 2;

  typedef enum logic [ModeW-1:0] {
    MODE_UNPROG   = 2'b00,
    MODE_ACCESSED = 2'b01,
    MODE_COMPLETE = 2'b10,
    MODE_OPER     = 2'b11
  } iscMode_e;

  typedef enum logic [KindW-1:0] {
    KIND_TEST    = 2'b00,
    KIND_ENABLE  = 2'b01,
    KIND_DISABLE = 2'b10,
    KIND_OTHER   = 2'b11
  } insnKind_e;

  typedef struct packed {
    logic latchDone;
    logic clearDone;
  } iscStrobe_t;
endpackage

// File: rtl/isc_mode_ctrl.sv
module isc_mode_ctrl
  import isc_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porEvt,
  input  logic             tlrEvt,
  input  logic             loadEvt,
  input  logic             execEvt,
  input  logic [KindW-1:0] insnKind,
  input  logic             doneReg,
  output iscMode_e         modeQ,
  output iscStrobe_t       strb
);
  iscMode_e modeD;
  iscMode_e exitMode;
  logic     disableHit;
  logic     enableHit;

  assign exitMode   = doneReg ? MODE_COMPLETE : MODE_UNPROG;
  assign enableHit  = execEvt && (insnKind == KIND_ENABLE);
  assign disableHit = (execEvt || loadEvt) && (insnKind == KIND_DISABLE);

  always_comb begin
    modeD = modeQ;
    if (porEvt) begin
      modeD = MODE_UNPROG;
    end else if (tlrEvt) begin
      if (modeQ == MODE_COMPLETE) modeD = doneReg ? MODE_OPER : MODE_UNPROG;
    end else if (modeQ == MODE_ACCESSED) begin
      if (disableHit) modeD = exitMode;
    end else if (enableHit) begin
      modeD = MODE_ACCESSED;
    end
  end

  always_comb begin
    strb.clearDone = (modeD == MODE_UNPROG);
    strb.latchDone = (modeQ == MODE_ACCESSED) && (modeD == MODE_ACCESSED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modeQ <= MODE_UNPROG;
    else        modeQ <= modeD;
  end

  // R1
  por_to_unprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    porEvt |=> modeQ == MODE_UNPROG);
  // R2
  enable_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!porEvt && !tlrEvt && execEvt && insnKind == KIND_ENABLE) |=> modeQ == MODE_ACCESSED);
  // R5
  tlr_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!porEvt && tlrEvt && modeQ == MODE_COMPLETE && doneReg) |=> modeQ == MODE_OPER);
  // R6
  test_insn_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!porEvt && !tlrEvt && (loadEvt || execEvt) && insnKind == KIND_TEST) |=> $stable(modeQ));
endmodule

// File: rtl/isc_done_dp.sv
module isc_done_dp
  import isc_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       doneIn,
  input  iscStrobe_t strb,
  output logic       doneReg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              doneReg <= 1'b0;
    else if (strb.clearDone) doneReg <= 1'b0;
    else if (strb.latchDone) doneReg <= doneIn;
  end

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clearDone && !strb.latchDone) |=> $stable(doneReg));
  // R3
  done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchDone && !strb.clearDone) |=> doneReg == $past(doneIn));
endmodule

// File: rtl/isc_mode_tracker.sv
module isc_mode_tracker
  import isc_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porEvt,
  input  logic             tlrEvt,
  input  logic             loadEvt,
  input  logic             execEvt,
  input  logic [KindW-1:0] insnKind,
  input  logic             doneIn,
  output logic [ModeW-1:0] mode,
  output logic             iscEnabled,
  output logic             iscDone
);
  iscMode_e   modeQ;
  iscStrobe_t strb;
  logic       doneReg;

  isc_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .porEvt(porEvt), .tlrEvt(tlrEvt),
    .loadEvt(loadEvt), .execEvt(execEvt), .insnKind(insnKind),
    .doneReg(doneReg), .modeQ(modeQ), .strb(strb)
  );

  isc_done_dp u_dp (
    .clk(clk), .rst_n(rst_n), .doneIn(doneIn), .strb(strb), .doneReg(doneReg)
  );

  assign mode       = modeQ;
  assign iscEnabled = (modeQ == MODE_ACCESSED);
  assign iscDone    = doneReg;

  // R5
  oper_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OPER) |-> iscDone);
  // R9
  unprog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UNPROG) |-> !iscDone);
endmodule

// File: tb/isc_mode_tracker_tb.sv
module isc_mode_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic porEvt = 1'b0, tlrEvt = 1'b0, loadEvt = 1'b0, execEvt = 1'b0;
  logic [1:0] insnKind = 2'b00;
  logic doneIn = 1'b0;
  logic [1:0] mode;
  logic iscEnabled, iscDone;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [1:0] UNP = 2'b00, ACC = 2'b01, CMP = 2'b10, OPR = 2'b11;
  localparam logic [1:0] KT = 2'b00, KE = 2'b01, KD = 2'b10, KO = 2'b11;

  always #10ns clk = ~clk;

  isc_mode_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .porEvt(porEvt), .tlrEvt(tlrEvt),
    .loadEvt(loadEvt), .execEvt(execEvt), .insnKind(insnKind),
    .doneIn(doneIn), .mode(mode), .iscEnabled(iscEnabled), .iscDone(iscDone)
  );

  task automatic expect3(input string tag, input logic [1:0] m, input logic en, input logic dn);
    checks++;
    if (mode !== m || iscEnabled !== en || iscDone !== dn) begin
      failures++;
      $display("FAIL %s: mode/en/done got %b/%b/%b expected %b/%b/%b",
               tag, mode, iscEnabled, iscDone, m, en, dn);
    end
  endtask

  task automatic step(input logic p, input logic t, input logic l, input logic e, input logic [1:0] k);
    @(negedge clk);
    porEvt = p; tlrEvt = t; loadEvt = l; execEvt = e; insnKind = k;
    @(negedge clk);
    porEvt = 0; tlrEvt = 0; loadEvt = 0; execEvt = 0; insnKind = KT;
  endtask

  task automatic tReset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    expect3("R1 reset", UNP, 0, 0);
    rst_n = 1;
    @(negedge clk);
    expect3("R1 after release", UNP, 0, 0);
  endtask

  task automatic tEnable();
    step(0, 0, 1, 0, KE);
    expect3("R10 enable load only", UNP, 0, 0);
    step(0, 0, 0, 1, KE);
    expect3("R2 enable exec", ACC, 1, 0);
  endtask

  task automatic tAccessedHold();
    doneIn = 1;
    step(0, 0, 0, 0, KT);
    expect3("R3 done captured", ACC, 1, 1);
    step(0, 0, 0, 1, KO);
    expect3("R6 other exec", ACC, 1, 1);
    step(0, 0, 1, 0, KT);
    expect3("R6 test load", ACC, 1, 1);
    step(0, 1, 0, 0, KT);
    expect3("R7 tlr in accessed", ACC, 1, 1);
  endtask

  task automatic tToOperational();
    step(0, 0, 1, 0, KD);
    expect3("R4 disable load done set", CMP, 0, 1);
    doneIn = 0;
    step(0, 0, 0, 0, KT);
    expect3("R9 done held in complete", CMP, 0, 1);
    step(0, 1, 0, 0, KT);
    expect3("R5 tlr complete", OPR, 0, 1);
    step(0, 1, 0, 0, KT);
    expect3("R7 tlr in operational", OPR, 0, 1);
    step(0, 0, 0, 1, KT);
    expect3("R6 test exec", OPR, 0, 1);
  endtask

  task automatic tReenterAndDrop();
    step(0, 0, 0, 1, KE);
    expect3("R2 enable from operational", ACC, 1, 1);
    step(0, 0, 0, 0, KT);
    expect3("R3 done recaptured low", ACC, 1, 0);
    step(0, 0, 0, 1, KD);
    expect3("R4 disable exec done clear", UNP, 0, 0);
    doneIn = 1;
    step(0, 0, 0, 0, KT);
    expect3("R9 doneIn ignored in unprog", UNP, 0, 0);
    step(0, 1, 0, 0, KT);
    expect3("R7 tlr in unprog", UNP, 0, 0);
  endtask

  task automatic tSameCycleDone();
    step(0, 0, 0, 1, KE);
    step(0, 0, 0, 0, KT);
    expect3("R3 capture before disable", ACC, 1, 1);
    @(negedge clk);
    doneIn = 0; loadEvt = 1; insnKind = KD;
    @(negedge clk);
    loadEvt = 0; insnKind = KT;
    expect3("R4 decision uses captured done", CMP, 0, 1);
  endtask

  task automatic tPriority();
    step(0, 1, 0, 1, KE);
    expect3("R8 tlr over enable exec", OPR, 0, 1);
    step(1, 0, 0, 1, KE);
    expect3("R8 por over enable exec", UNP, 0, 0);
    doneIn = 1;
    step(0, 0, 0, 1, KE);
    step(0, 0, 0, 0, KT);
    step(0, 0, 1, 0, KD);
    expect3("R4 back in complete", CMP, 0, 1);
    step(1, 1, 0, 0, KT);
    expect3("R8 por over tlr", UNP, 0, 0);
    step(0, 0, 0, 1, KE);
    step(1, 0, 0, 0, KT);
    expect3("R1 por strobe from accessed", UNP, 0, 0);
  endtask

  task automatic tMidReset();
    step(0, 0, 0, 1, KE);
    expect3("R2 enable before reset", ACC, 1, 0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    expect3("R1 async reset mid run", UNP, 0, 0);
    rst_n = 1;
  endtask

  initial begin
    tReset();
    tEnable();
    tAccessedHold();
    tToOperational();
    tReenterAndDrop();
    tSameCycleDone();
    tPriority();
    tMidReset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule